// File: doc/BRIEF.md
# Two-Step Converter Conversion Controller

This block is the digital sequencing logic of a four-channel, eight-bit converter that resolves its result in two steps: a coarse nibble from one comparator bank, then a fine nibble from a second bank. The comparator banks are not modelled. Their decisions arrive as two 4-bit codes on input ports. The controller samples the upper code when the coarse phase ends and the lower code when the fine phase ends. It then presents the assembled byte on a tri-stated bus under host read control. All timing inside the block is counted in cycles of the system clock.

The host talks to the block in one of two bus styles, chosen by a mode pin. In single-read style, a read strobe starts the conversion. The block then runs both phases on internal counters, and a ready output is pulled low while the host waits. In write-then-read style, the write strobe starts the conversion. The coarse decision is taken when the write strobe returns high, and the fine phase is counted from that point. A read may arrive before completion, and chip select and read may both be held low permanently. A second pin chooses between sample and track behaviour. The only digital effect of that pin is which falling edge captures the channel address. An internal power-on timer keeps the block quiet after reset.

All host pins pass through two-flop synchronisers before edges are detected. Both mode pins are taken into account only while no conversion is running.

Top module: `adc_ctrl_top`

## Requirements
- R1: `chan_sel` holds the captured address `{addr[1],addr[0]}`. Code 0 selects analog input 1, code 1 input 2, code 2 input 3 and code 3 input 4. This value is visible on the bus cycle of the result.
- R2: With `smp_sel` low, the address is captured on the falling edge that starts the conversion. That is the read falling edge when `mode_wr` is 0, and the write falling edge when `mode_wr` is 1. Later address changes do not affect that conversion.
- R3: With `smp_sel` high, the address is captured on the falling edge of chip select in either bus style. It is kept for every conversion started while chip select stays low.
- R4: With `mode_wr` 0, a read falling edge while chip select is low starts a conversion. The coarse phase lasts MSB_CYC cycles and the fine phase LSB_CYC cycles. `int_n` falls exactly 3+MSB_CYC+LSB_CYC clock edges after the read pin falls.
- R5: With `mode_wr` 1, a write falling edge while chip select is low starts a conversion. The upper nibble is sampled when write rises, and completion comes LSB_CYC cycles after that.
- R6: At completion `int_n` goes low and the result `{msb_code, lsb_code}` is latched, with the coarse code in bits 7:4. `int_n` falls only after a fine-phase strobe.
- R7: The bus is driven (`db_en` high) only while chip select and read are both low and a result is held. A rising read or chip-select edge releases the bus and returns `int_n` high.
- R8: A read that goes low before completion leaves the bus released until completion. The bus then enables in the same cycle that `int_n` falls, and never while a conversion runs.
- R9: With chip select and read tied low in write-then-read style, each result appears on the bus by itself. A new write cycle returns `int_n` high until the next completion.
- R10: With `mode_wr` 0, `rdy_low` is asserted from the chip-select falling edge until completion. It is never asserted in write-then-read style.
- R11: For POR_CYC cycles after reset, chip select is ignored, `int_n` stays high, the bus stays released and `rdy_low` stays low.
- R12: Start edges and mode-pin changes that arrive during a conversion have no effect on that conversion's result, timing or ready handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low (write-then-read style) |
| mode_wr | input | 1 | Bus style: 0 single-read, 1 write-then-read |
| smp_sel | input | 1 | 1 sample behaviour, 0 track behaviour |
| addr | input | 2 | Channel address |
| msb_code | input | 4 | Coarse comparator decision |
| lsb_code | input | 4 | Fine comparator decision |
| chan_sel | output | 2 | Captured channel select |
| msb_strobe | output | 1 | One-cycle pulse when the coarse nibble is taken |
| lsb_strobe | output | 1 | One-cycle pulse when the fine nibble is taken |
| int_n | output | 1 | End-of-conversion flag, active low |
| rdy_low | output | 1 | Pull-down enable of the open-drain ready line |
| db_en | output | 1 | Bus drive enable |
| db | output | 8 | Tri-stated result bus |

## Verification
Two functions can land in the same cycle: completion of the fine phase, and a host read strobe that is already low. That is the early-read path. The bench lowers read a few cycles after write rises, checks that the bus stays released during the fine phase, and has the monitor confirm that `int_n` is already low on the first cycle the bus enables. A second collision is a write pulse during the fine phase, where a start edge and a write-rise clear meet a running conversion. The bench changes the coarse code at that moment and judges that the byte read back still carries the code sampled at the first write rise.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    localparam int NIB_W  = 4;
    localparam int DATA_W = 2 * NIB_W;
    localparam int CH_W   = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RMSB = 2'd1,
        ST_WMSB = 2'd2,
        ST_LSB  = 2'd3
    } conv_state_e;

    typedef struct packed {
        logic            cs_n;
        logic            rd_n;
        logic            wr_n;
        logic            mode_wr;
        logic            smp_sel;
        logic [CH_W-1:0] addr;
    } pin_bundle_t;

    localparam int PIN_W = $bits(pin_bundle_t);

    localparam pin_bundle_t PIN_REST = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                         mode_wr: 1'b0, smp_sel: 1'b0,
                                         addr: '0};

    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } result_t;

    // Which detected edge captures the channel address.
    function automatic logic addr_take(input logic smp, input logic wr_style,
                                       input logic cs_f, input logic rd_f,
                                       input logic wr_f);
        if (smp)
            return cs_f;
        else if (wr_style)
            return wr_f;
        else
            return rd_f;
    endfunction

endpackage

// File: rtl/adc_ctrl_sync.sv
module adc_ctrl_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/adc_ctrl_por.sv
module adc_ctrl_por #(
    parameter int POR_CYC = 300
) (
    input  logic clk,
    input  logic rst,
    output logic por_done
);
    localparam int CW = $clog2(POR_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            por_done <= 1'b0;
        end else if (!por_done) begin
            if (cnt == CW'(POR_CYC - 1))
                por_done <= 1'b1;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
    import adc_ctrl_pkg::*;
#(
    parameter int MSB_CYC = 6,
    parameter int LSB_CYC = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  pin_bundle_t      pins,
    input  logic             por_done,
    input  logic [NIB_W-1:0] msb_code,
    input  logic [NIB_W-1:0] lsb_code,
    output logic [CH_W-1:0]  chan_sel,
    output logic             msb_strobe,
    output logic             lsb_strobe,
    output logic             int_n,
    output logic             rdy_low,
    output logic             db_en,
    output result_t          result
);
    localparam int CMAX  = (MSB_CYC > LSB_CYC) ? MSB_CYC : LSB_CYC;
    localparam int CNT_W = $clog2(CMAX + 1);

    conv_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    pin_bundle_t      prev_q;
    logic             cs_prev_q;
    logic             mode_q, smp_q;
    logic [NIB_W-1:0] msb_q;
    logic             done_q;
    logic             rdy_q;
    logic [CH_W-1:0]  chan_q;

    logic cs_act, cs_fall, cs_rise;
    logic rd_fall, rd_rise, wr_fall, wr_rise;
    logic idle, start_rd, start_wr, start;

    assign cs_act  = !pins.cs_n && por_done;
    assign cs_fall = cs_act && !cs_prev_q;
    assign cs_rise = !cs_act && cs_prev_q;
    assign rd_fall = prev_q.rd_n && !pins.rd_n;
    assign rd_rise = !prev_q.rd_n && pins.rd_n;
    assign wr_fall = prev_q.wr_n && !pins.wr_n;
    assign wr_rise = !prev_q.wr_n && pins.wr_n;

    assign idle     = (state_q == ST_IDLE);
    assign start_rd = idle && !mode_q && cs_act && rd_fall;
    assign start_wr = idle &&  mode_q && cs_act && wr_fall;
    assign start    = start_rd || start_wr;

    assign msb_strobe = ((state_q == ST_RMSB) && (cnt_q == '0)) ||
                        ((state_q == ST_WMSB) && wr_rise);
    assign lsb_strobe = (state_q == ST_LSB) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= PIN_REST;
            cs_prev_q <= 1'b0;
        end else begin
            prev_q    <= pins;
            cs_prev_q <= cs_act;
        end
    end

    // Mode pins are frozen for the duration of a conversion.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            smp_q  <= 1'b0;
        end else if (idle) begin
            mode_q <= pins.mode_wr;
            smp_q  <= pins.smp_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            chan_q <= '0;
        else if (idle && cs_act && addr_take(smp_q, mode_q, cs_fall, rd_fall, wr_fall))
            chan_q <= pins.addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            msb_q   <= '0;
            result  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_rd) begin
                        state_q <= ST_RMSB;
                        cnt_q   <= CNT_W'(MSB_CYC - 1);
                    end else if (start_wr) begin
                        state_q <= ST_WMSB;
                    end
                end
                ST_RMSB, ST_WMSB: begin
                    if (msb_strobe) begin
                        msb_q   <= msb_code;
                        state_q <= ST_LSB;
                        cnt_q   <= CNT_W'(LSB_CYC - 1);
                    end else if (state_q == ST_RMSB) begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_LSB: begin
                    if (lsb_strobe) begin
                        result  <= '{hi: msb_q, lo: lsb_code};
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Completion takes priority over any clearing edge in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else if (lsb_strobe)
            done_q <= 1'b1;
        else if (start || rd_rise || cs_rise || (mode_q && wr_rise))
            done_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdy_q <= 1'b0;
        else if (cs_rise || lsb_strobe || mode_q)
            rdy_q <= 1'b0;
        else if (cs_fall)
            rdy_q <= 1'b1;
    end

    assign chan_sel = chan_q;
    assign int_n    = !done_q;
    assign rdy_low  = rdy_q;
    assign db_en    = cs_act && !pins.rd_n && done_q;

    p_por_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !por_done |-> (int_n && !db_en && !rdy_low));

    p_int_after_lsb_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n) |-> $past(lsb_strobe));

    p_chan_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(chan_sel));

    p_rdy_release_r10: assert property (@(posedge clk) disable iff (rst)
        lsb_strobe |=> !rdy_low);

    p_bus_quiet_busy_r8: assert property (@(posedge clk) disable iff (rst)
        !idle |-> !db_en);

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(msb_strobe && lsb_strobe));

endmodule

// File: rtl/adc_ctrl_top.sv
module adc_ctrl_top
    import adc_ctrl_pkg::*;
#(
    parameter int MSB_CYC = 6,
    parameter int LSB_CYC = 12,
    parameter int POR_CYC = 300
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        mode_wr,
    input  logic        smp_sel,
    input  logic [1:0]  addr,
    input  logic [3:0]  msb_code,
    input  logic [3:0]  lsb_code,
    output logic [1:0]  chan_sel,
    output logic        msb_strobe,
    output logic        lsb_strobe,
    output logic        int_n,
    output logic        rdy_low,
    output logic        db_en,
    output logic [7:0]  db
);
    pin_bundle_t raw_pins, sync_pins;
    logic        por_done;
    result_t     result;

    assign raw_pins = '{cs_n: cs_n, rd_n: rd_n, wr_n: wr_n,
                        mode_wr: mode_wr, smp_sel: smp_sel, addr: addr};

    adc_ctrl_sync #(
        .W       (PIN_W),
        .RST_VAL (PIN_REST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (sync_pins)
    );

    adc_ctrl_por #(
        .POR_CYC (POR_CYC)
    ) u_por (
        .clk      (clk),
        .rst      (rst),
        .por_done (por_done)
    );

    adc_ctrl_seq #(
        .MSB_CYC (MSB_CYC),
        .LSB_CYC (LSB_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pins       (sync_pins),
        .por_done   (por_done),
        .msb_code   (msb_code),
        .lsb_code   (lsb_code),
        .chan_sel   (chan_sel),
        .msb_strobe (msb_strobe),
        .lsb_strobe (lsb_strobe),
        .int_n      (int_n),
        .rdy_low    (rdy_low),
        .db_en      (db_en),
        .result     (result)
    );

    assign db = db_en ? DATA_W'(result) : {DATA_W{1'bz}};

endmodule

// File: tb/tb_adc_ctrl_top.sv
module tb_adc_ctrl_top;

    localparam int MSB_CYC = 6;
    localparam int LSB_CYC = 12;
    localparam int POR_CYC = 300;
    localparam int RD_LAT  = 3 + MSB_CYC + LSB_CYC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic       mode_wr = 1'b0, smp_sel = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [3:0] msb_code = 4'd0, lsb_code = 4'd0;
    logic [1:0] chan_sel;
    logic       msb_strobe, lsb_strobe, int_n, rdy_low, db_en;
    logic [7:0] db;

    always #5 clk = ~clk;

    adc_ctrl_top #(
        .MSB_CYC (MSB_CYC),
        .LSB_CYC (LSB_CYC),
        .POR_CYC (POR_CYC)
    ) dut (
        .clk (clk), .rst (rst), .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n),
        .mode_wr (mode_wr), .smp_sel (smp_sel), .addr (addr),
        .msb_code (msb_code), .lsb_code (lsb_code), .chan_sel (chan_sel),
        .msb_strobe (msb_strobe), .lsb_strobe (lsb_strobe), .int_n (int_n),
        .rdy_low (rdy_low), .db_en (db_en), .db (db)
    );

    typedef struct packed {
        logic [1:0] chan;
        logic [7:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   por_strobes = 0;
    logic prev_en = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] ch, input logic [7:0] d);
        exp_q.push_back('{chan: ch, data: d});
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_int(input string req);
        for (int i = 0; i < 300 && int_n; i++) @(negedge clk);
        chk(!int_n, req, int_n, 0);
    endtask

    // Monitor: every new bus drive pops one expected item (R1, R6, R8).
    always @(negedge clk) begin
        if (rst) begin
            prev_en <= 1'b0;
        end else begin
            if (db_en && !prev_en) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected bus drive", db, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(db == e.data, "R6 result byte", db, e.data);
                    chk(chan_sel == e.chan, "R1 channel select", chan_sel, e.chan);
                    chk(!int_n, "R8 int low when bus enables", int_n, 0);
                end
            end
            prev_en <= db_en;
            if (msb_strobe && !dut.u_por.por_done) por_strobes++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=expired expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(1);
        // Reset state
        chk(int_n == 1'b1, "R11 reset int_n", int_n, 1);
        chk(db_en == 1'b0, "R11 reset db_en", db_en, 0);
        chk(rdy_low == 1'b0, "R11 reset rdy_low", rdy_low, 0);

        // R11: power-on window blocks chip select
        cs_n = 1'b0; rd_n = 1'b0;
        cyc(100);
        chk(int_n == 1'b1, "R11 int held high", int_n, 1);
        chk(db_en == 1'b0, "R11 bus released", db_en, 0);
        chk(rdy_low == 1'b0, "R11 ready idle", rdy_low, 0);
        chk(por_strobes == 0, "R11 no conversion", por_strobes, 0);
        cs_n = 1'b1; rd_n = 1'b1;
        cyc(POR_CYC);

        // R4, R10, R2, R7: single-read style, track, exact latency
        mode_wr = 1'b0; smp_sel = 1'b0; addr = 2'd2;
        msb_code = 4'hA; lsb_code = 4'h5;
        cyc(4);
        cs_n = 1'b0;
        cyc(4);
        chk(rdy_low == 1'b1, "R10 ready low after cs", rdy_low, 1);
        push(2'd2, 8'hA5);
        rd_n = 1'b0;
        cyc(4);
        addr = 2'd0;
        cyc(RD_LAT - 5);
        chk(int_n == 1'b1, "R4 not early", int_n, 1);
        cyc(1);
        chk(int_n == 1'b0, "R4 exact completion", int_n, 0);
        chk(db_en == 1'b1, "R7 bus on rd&cs", db_en, 1);
        chk(rdy_low == 1'b0, "R10 ready released", rdy_low, 0);
        cyc(2);
        rd_n = 1'b1;
        cyc(4);
        chk(int_n == 1'b1, "R7 rd rise clears int", int_n, 1);
        chk(db_en == 1'b0, "R7 rd rise releases bus", db_en, 0);
        cs_n = 1'b1;
        cyc(4);
        chk(rdy_low == 1'b0, "R10 ready idle", rdy_low, 0);

        // R7: chip select rise clears int while rd stays low
        addr = 2'd0; msb_code = 4'h1; lsb_code = 4'hE;
        cs_n = 1'b0; cyc(4);
        push(2'd0, 8'h1E);
        rd_n = 1'b0;
        wait_int("R4 conversion 2");
        cyc(2);
        cs_n = 1'b1;
        cyc(4);
        chk(int_n == 1'b1, "R7 cs rise clears int", int_n, 1);
        chk(db_en == 1'b0, "R7 cs rise releases bus", db_en, 0);
        rd_n = 1'b1;
        cyc(4);

        // R3: sample behaviour, address on cs fall, kept while cs low
        smp_sel = 1'b1; addr = 2'd3; msb_code = 4'h7; lsb_code = 4'h2;
        cyc(4);
        cs_n = 1'b0;
        cyc(4);
        addr = 2'd0;
        cyc(2);
        push(2'd3, 8'h72);
        rd_n = 1'b0;
        wait_int("R3 conversion a");
        cyc(2);
        rd_n = 1'b1;
        cyc(4);
        addr = 2'd1; msb_code = 4'h3; lsb_code = 4'h3;
        cyc(2);
        push(2'd3, 8'h33);
        rd_n = 1'b0;
        wait_int("R3 conversion b");
        cyc(2);
        rd_n = 1'b1; cs_n = 1'b1;
        cyc(4);

        // R2, R5, R7, R10: write-then-read, track, read after completion
        smp_sel = 1'b0; mode_wr = 1'b1; addr = 2'd1;
        msb_code = 4'h4; lsb_code = 4'hB;
        cyc(4);
        cs_n = 1'b0;
        cyc(4);
        chk(rdy_low == 1'b0, "R10 no ready in wr style", rdy_low, 0);
        wr_n = 1'b0;
        cyc(4);
        addr = 2'd3;
        cyc(2);
        wr_n = 1'b1;
        wait_int("R5 conversion");
        cyc(2);
        chk(db_en == 1'b0, "R7 bus off while rd high", db_en, 0);
        push(2'd1, 8'h4B);
        rd_n = 1'b0;
        cyc(4);
        rd_n = 1'b1; cs_n = 1'b1;
        cyc(4);

        // R5, R8: coarse code taken at write rise, early read
        addr = 2'd0; msb_code = 4'h3; lsb_code = 4'h1;
        cs_n = 1'b0; cyc(2);
        wr_n = 1'b0;
        cyc(3);
        msb_code = 4'h9;
        cyc(3);
        wr_n = 1'b1;
        cyc(3);
        rd_n = 1'b0;
        cyc(2);
        msb_code = 4'h2; lsb_code = 4'h7;
        push(2'd0, 8'h97);
        chk(db_en == 1'b0, "R8 bus released before completion", db_en, 0);
        chk(int_n == 1'b1, "R8 int high before completion", int_n, 1);
        wait_int("R8 early read completion");
        cyc(2);
        rd_n = 1'b1; cs_n = 1'b1;
        cyc(4);

        // R12: write pulse during fine phase ignored
        addr = 2'd2; msb_code = 4'h6; lsb_code = 4'hC;
        cs_n = 1'b0; cyc(2);
        wr_n = 1'b0; cyc(4);
        wr_n = 1'b1; cyc(5);
        msb_code = 4'hF; wr_n = 1'b0;
        cyc(1);
        wr_n = 1'b1;
        wait_int("R12 conversion");
        cyc(2);
        push(2'd2, 8'h6C);
        rd_n = 1'b0; cyc(4);
        rd_n = 1'b1; cs_n = 1'b1;
        cyc(4);

        // R9: stand-alone, cs and rd held low
        addr = 2'd2; msb_code = 4'hC; lsb_code = 4'hD;
        cs_n = 1'b0; rd_n = 1'b0; cyc(2);
        push(2'd2, 8'hCD);
        wr_n = 1'b0; cyc(4);
        wr_n = 1'b1;
        wait_int("R9 first result");
        cyc(3);
        msb_code = 4'h4; lsb_code = 4'h4;
        push(2'd2, 8'h44);
        wr_n = 1'b0;
        cyc(4);
        chk(int_n == 1'b1, "R9 new write returns int high", int_n, 1);
        chk(db_en == 1'b0, "R9 bus off during conversion", db_en, 0);
        wr_n = 1'b1;
        wait_int("R9 second result");
        cyc(2);
        rd_n = 1'b1; cs_n = 1'b1;
        cyc(4);

        // R12: mode pin change mid-conversion ignored
        mode_wr = 1'b0; addr = 2'd1; msb_code = 4'h8; lsb_code = 4'h0;
        cyc(4);
        cs_n = 1'b0; cyc(4);
        push(2'd1, 8'h80);
        rd_n = 1'b0;
        cyc(5);
        mode_wr = 1'b1;
        cyc(RD_LAT - 6);
        chk(rdy_low == 1'b1, "R12 ready kept despite mode change", rdy_low, 1);
        chk(int_n == 1'b1, "R12 not early", int_n, 1);
        cyc(1);
        chk(int_n == 1'b0, "R12 timing unchanged", int_n, 0);
        chk(rdy_low == 1'b0, "R12 ready released at end", rdy_low, 0);
        cyc(2);
        rd_n = 1'b1; cs_n = 1'b1;
        cyc(10);

        chk(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule